// File: doc/BRIEF.md
# Serial Character Slot Timer

This block works out how many ticks one serial character occupies on the line, and it times a transmit slot and a receive slot of that length. The length comes from a 16-bit baud divisor, which is written as two bytes, and from a line-control byte. The line-control byte picks the word length, the parity enable and the stop-bit choice. The character length counts the start bit, the data bits, the optional parity bit and a stop allowance. The stop allowance can be the fractional 1.5 bits. Inside the block the length is held in half-bit units. The product of divisor and half-bits is shifted right by one, so a half tick is dropped.

Software-side write strobes load the divisor bytes and the line-control byte. Only a low-divisor write or a line-control write refreshes the stored duration. A high-divisor write is kept but takes effect at the next refresh. Each slot is armed by a start pulse and advances on `tick_en`. It ends with a one-clock done pulse on the tick that finds its counter at or past the duration. The block measures whole-character slots only: it does not shift bits, build parity on the wire or sample the line.

Top module: `char_slot_timer`

## Requirements
- R1: Line-control bits [1:0] give the data-bit count as 5 plus their value. Bit 3 adds one parity bit when set. One start bit is always counted.
- R2: Line-control bit 2 set gives a stop allowance of 2 bits. When it is clear, the allowance is 1 bit, except with 5-bit words (bits [1:0] = 0), where it is 1.5 bits.
- R3: `char_ticks` equals the 16-bit divisor {high byte, low byte} times the bits per character, rounded down to an integer.
- R4: `char_ticks` is refreshed at the clock edge of a low-divisor write or a line-control write, using the incoming values. A high-divisor write on its own leaves `char_ticks` unchanged until the next refresh.
- R5: After reset `char_ticks` is 0, both done outputs are low, the divisor is 0 and the line-control byte is 0x03.
- R6: A running slot raises its done output for exactly one clock, in the cycle after the tick that finds its counter at or above `char_ticks`. With duration D this is the (D+1)-th tick after start. Clock cycles without `tick_en` do not advance the slot.
- R7: With a divisor of zero, a slot completes on the first tick after its start.
- R8: A start pulse on a running slot restarts it from zero. A tick in the same cycle as a start is not counted.
- R9: The transmit and receive slots run independently. A start or done on one has no effect on the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_lo_we | input | 1 | Write strobe for the divisor low byte (triggers a refresh) |
| div_hi_we | input | 1 | Write strobe for the divisor high byte (no refresh) |
| line_ctl_we | input | 1 | Write strobe for the line-control byte (triggers a refresh) |
| wr_data | input | 8 | Byte written by any strobe |
| tick_en | input | 1 | Time-base tick that advances running slots |
| tx_start | input | 1 | Arms or restarts the transmit slot |
| rx_start | input | 1 | Arms or restarts the receive slot |
| char_ticks | output | 20 | Stored character duration in ticks |
| tx_done | output | 1 | One-clock pulse at the end of a transmit slot |
| rx_done | output | 1 | One-clock pulse at the end of a receive slot |

## Verification
The duration is checked for every line-control setting that changes the bit count: all four word lengths, with and without parity, and both stop choices. This tells the 1.5-bit case apart from the 1-bit and 2-bit cases. An odd divisor with a fractional bit count shows whether the half tick is dropped rather than rounded up. A low-byte write, a high-byte write and a line-control write are issued in turn, which separates the two refresh triggers from the one store that does not refresh. The slot tests count ticks to done with ticks that have gaps between them, with a zero divisor, with a restart partway through a slot, and with only one slot armed. Together these catch an off-by-one end, idle-cycle counting and crosstalk between the slots.

// File: rtl/cst_pkg.sv
package cst_pkg;

  // Line-control byte; field positions are decoded by neighbouring logic.
  typedef struct packed {
    logic [3:0] upper;     // not used by this block
    logic       par_en;    // bit 3
    logic       two_stop;  // bit 2
    logic [1:0] wlen;      // bits 1:0, data bits = 5 + wlen
  } line_ctl_t;

  localparam int HB_W = 5;  // half-bit count fits 15..24

  // Bits per character in half-bit units.
  function automatic logic [HB_W-1:0] half_bits_f(line_ctl_t lc);
    logic [HB_W-1:0] whole;
    logic [HB_W-1:0] stop_h;
    whole = HB_W'(1) + HB_W'(5) + HB_W'(lc.wlen) + HB_W'(lc.par_en);
    if (lc.two_stop)       stop_h = HB_W'(4);
    else if (lc.wlen == 0) stop_h = HB_W'(3);
    else                   stop_h = HB_W'(2);
    return (whole << 1) + stop_h;
  endfunction

endpackage

// File: rtl/cst_bits_calc.sv
module cst_bits_calc
  import cst_pkg::*;
(
  input  line_ctl_t       lc,
  output logic [HB_W-1:0] half_bits
);
  always_comb begin
    half_bits = half_bits_f(lc);
    // R1/R2: 1 start + 5..8 data + 0..1 parity + 1..2 stop -> 15..24 half bits
    a_half_range_r2: assert (half_bits >= HB_W'(15) && half_bits <= HB_W'(24) || $isunknown(lc))
      else $error("half-bit count out of range");
  end
endmodule

// File: rtl/cst_cfg_regs.sv
module cst_cfg_regs
  import cst_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DUR_W = DIV_W + HB_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_lo_we,
  input  logic             div_hi_we,
  input  logic             line_ctl_we,
  input  logic [7:0]       wr_data,
  output logic [DUR_W-1:0] dur
);
  localparam int PROD_W = DIV_W + HB_W;

  logic [7:0]       div_lo_q, div_hi_q;
  line_ctl_t        lc_q;
  logic [7:0]       div_lo_nx, div_hi_nx;
  line_ctl_t        lc_nx;
  logic [HB_W-1:0]  half_bits;
  logic [PROD_W-1:0] prod;
  logic             refresh_evt;

  assign div_lo_nx   = div_lo_we ? wr_data : div_lo_q;
  assign div_hi_nx   = div_hi_we ? wr_data : div_hi_q;
  assign lc_nx       = line_ctl_we ? line_ctl_t'(wr_data) : lc_q;
  assign refresh_evt = div_lo_we | line_ctl_we;

  cst_bits_calc u_bits (.lc(lc_nx), .half_bits(half_bits));

  assign prod = PROD_W'(DIV_W'({div_hi_nx, div_lo_nx})) * PROD_W'(half_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_lo_q <= '0;
      div_hi_q <= '0;
      lc_q     <= line_ctl_t'(8'h03);
      dur      <= '0;
    end else begin
      div_lo_q <= div_lo_nx;
      div_hi_q <= div_hi_nx;
      lc_q     <= lc_nx;
      if (refresh_evt) dur <= prod[PROD_W-1:1];
    end
  end

  // R5: duration cleared by reset
  p_reset_dur_zero_r5: assert property (@(posedge clk) !rst_n |=> dur == '0);
  // R4: without a refresh write the duration holds
  p_hold_without_refresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_evt |=> $stable(dur));
  // R4: a high-byte write alone never moves the duration
  p_hi_alone_no_refresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_hi_we && !div_lo_we && !line_ctl_we) |=> $stable(dur));
endmodule

// File: rtl/cst_slot_timer.sv
module cst_slot_timer #(
  parameter int DUR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             start,
  input  logic [DUR_W-1:0] dur,
  output logic             done
);
  logic             active;
  logic [DUR_W-1:0] cnt;
  logic             limit_hit;
  logic             end_evt;

  assign limit_hit = cnt >= dur;
  assign end_evt   = !start && active && tick_en && limit_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active && tick_en) begin
        if (limit_hit) begin
          active <= 1'b0;
          cnt    <= '0;
          done   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R6: done lasts one clock
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: done only follows a tick
  p_done_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tick_en));
  // R6: the slot is idle once it has ended
  p_idle_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);
  // R8: a start always leaves the counter at zero and running
  p_start_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && cnt == '0 && !done));
endmodule

// File: rtl/char_slot_timer.sv
module char_slot_timer #(
  parameter int DIV_W     = 16,
  parameter int NUM_SLOTS = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               div_lo_we,
  input  logic                               div_hi_we,
  input  logic                               line_ctl_we,
  input  logic [7:0]                         wr_data,
  input  logic                               tick_en,
  input  logic                               tx_start,
  input  logic                               rx_start,
  output logic [DIV_W+cst_pkg::HB_W-2:0]     char_ticks,
  output logic                               tx_done,
  output logic                               rx_done
);
  localparam int DUR_W = DIV_W + cst_pkg::HB_W - 1;

  logic [NUM_SLOTS-1:0] slot_start;
  logic [NUM_SLOTS-1:0] slot_done;

  assign slot_start = NUM_SLOTS'({rx_start, tx_start});
  assign tx_done    = slot_done[0];
  assign rx_done    = slot_done[1];

  cst_cfg_regs #(.DIV_W(DIV_W), .DUR_W(DUR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .div_lo_we(div_lo_we), .div_hi_we(div_hi_we), .line_ctl_we(line_ctl_we),
    .wr_data(wr_data), .dur(char_ticks)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    cst_slot_timer #(.DUR_W(DUR_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .start(slot_start[s]), .dur(char_ticks), .done(slot_done[s])
    );
  end

  // R9: a start on one slot cannot end the other in the next cycle
  p_tx_start_no_rx_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !rx_start && !rx_done && !tick_en) |=> !rx_done);
endmodule

// File: tb/tb_char_slot_timer.sv
module tb_char_slot_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_lo_we = 0, div_hi_we = 0, line_ctl_we = 0;
  logic [7:0]  wr_data = 0;
  logic        tick_en = 0, tx_start = 0, rx_start = 0;
  logic [19:0] char_ticks;
  logic        tx_done, rx_done;

  int n_run = 0;
  int n_fail = 0;
  int div_now = 0;

  always #2 clk = ~clk;

  char_slot_timer dut (
    .clk(clk), .rst_n(rst_n), .div_lo_we(div_lo_we), .div_hi_we(div_hi_we),
    .line_ctl_we(line_ctl_we), .wr_data(wr_data), .tick_en(tick_en),
    .tx_start(tx_start), .rx_start(rx_start), .char_ticks(char_ticks),
    .tx_done(tx_done), .rx_done(rx_done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_ticks(input int dv, input int lc);
    real bits;
    bits = 1.0 + 5.0 + real'(lc & 3) + (((lc >> 3) & 1) != 0 ? 1.0 : 0.0);
    if (((lc >> 2) & 1) != 0) bits += 2.0;
    else if ((lc & 3) == 0)   bits += 1.5;
    else                      bits += 1.0;
    return int'($floor(real'(dv) * bits));
  endfunction

  task automatic wr(input int kind, input int val);
    @(negedge clk);
    wr_data = val[7:0];
    div_lo_we = (kind == 0); div_hi_we = (kind == 1); line_ctl_we = (kind == 2);
    @(negedge clk);
    div_lo_we = 0; div_hi_we = 0; line_ctl_we = 0;
  endtask

  task automatic set_div(input int dv);
    wr(1, dv >> 8);
    wr(0, dv & 8'hff);
    div_now = dv;
  endtask

  task automatic pulse_start(input bit tx, input bit rx);
    @(negedge clk);
    tx_start = tx; rx_start = rx;
    @(negedge clk);
    tx_start = 0; rx_start = 0;
  endtask

  // Issue ticks with one idle cycle between them; return tick count at done.
  task automatic ticks_to_done(input bit use_rx, input int limit, output int k, output int other);
    k = 0; other = 0;
    for (int i = 1; i <= limit; i++) begin
      tick_en = 1;
      @(negedge clk);
      tick_en = 0;
      if ((use_rx ? tx_done : rx_done)) other++;
      if ((use_rx ? rx_done : tx_done)) begin k = i; break; end
      @(negedge clk);
      if (tx_done || rx_done) other++;
    end
  endtask

  task automatic t_reset();
    check("R5 char_ticks", char_ticks, 0);
    check("R5 tx_done", tx_done, 0);
    check("R5 rx_done", rx_done, 0);
    wr(0, 8'h00); // refresh with reset line control (8 bits) and zero divisor
    check("R5 reset divisor zero", char_ticks, 0);
  endtask

  task automatic t_lengths();
    set_div(3);
    for (int lc = 0; lc < 16; lc++) begin
      wr(2, lc);
      check($sformatf("R1/R2/R3 lcr=%0h", lc), char_ticks, exp_ticks(3, lc));
    end
    wr(2, 8'h00);
    check("R3 half tick dropped 3x7.5", char_ticks, 22);
    wr(2, 8'h0F);
    check("R1 8-bit parity 2 stop", char_ticks, 36);
  endtask

  task automatic t_refresh();
    wr(2, 8'h03);
    set_div(2);
    check("R4 low write refresh", char_ticks, 20);
    wr(1, 8'h01);
    check("R4 high write alone no refresh", char_ticks, 20);
    wr(2, 8'h03);
    check("R4 line write uses new high byte", char_ticks, exp_ticks(258, 3));
    wr(1, 8'h00);
    check("R4 high write alone keeps", char_ticks, exp_ticks(258, 3));
    wr(0, 8'h01);
    check("R4 low write refresh", char_ticks, 10);
    div_now = 1;
  endtask

  task automatic t_slot(input int dv, input int lc, input string tag);
    int k, o, d;
    set_div(dv); wr(2, lc);
    d = exp_ticks(dv, lc);
    pulse_start(1, 0);
    repeat (3) @(negedge clk);
    check({tag, " idle cycles do not advance"}, tx_done, 0);
    ticks_to_done(0, d + 5, k, o);
    check({tag, " tx done at D+1"}, k, d + 1);
    check("R9 rx quiet during tx slot", o, 0);
    @(negedge clk);
    check("R6 done lasts one clock", tx_done, 0);
  endtask

  task automatic t_zero();
    int k, o;
    set_div(0); wr(2, 8'h0F);
    check("R7 zero duration", char_ticks, 0);
    pulse_start(0, 1);
    ticks_to_done(1, 4, k, o);
    check("R7 first tick ends slot", k, 1);
  endtask

  task automatic t_restart();
    int k, o;
    set_div(1); wr(2, 8'h03); // 10 ticks
    pulse_start(1, 0);
    repeat (4) begin
      tick_en = 1; @(negedge clk); tick_en = 0; @(negedge clk);
    end
    @(negedge clk); tx_start = 1; tick_en = 1;
    @(negedge clk); tx_start = 0; tick_en = 0;
    ticks_to_done(0, 20, k, o);
    check("R8 restart counts from zero", k, 11);
  endtask

  task automatic t_both();
    int k, o;
    set_div(1); wr(2, 8'h00); // 7 ticks
    pulse_start(1, 0);
    repeat (3) begin
      tick_en = 1; @(negedge clk); tick_en = 0; @(negedge clk);
    end
    pulse_start(0, 1);
    ticks_to_done(0, 20, k, o);
    check("R9 tx independent of rx start", k, 5);
    ticks_to_done(1, 20, k, o);
    check("R9 rx completes on its own count", k, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_refresh();
    t_slot(1, 8'h03, "R6 8N1");
    t_slot(3, 8'h00, "R6 5-bit 1.5 stop");
    t_slot(258, 8'h03, "R6 long");
    t_zero();
    t_restart();
    t_both();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule